// File: doc/BRIEF.md
# Weak-Row Read-Refresh Scheduler

This block belongs to a DRAM memory controller. It asks for chip-wide auto-refresh at a relaxed interval. The default relaxed interval is three times the usual 64 ms period. Some rows cannot hold their charge for that long. The block keeps those rows alive by asking for an ordinary read of each one on that row's own shorter schedule. A read opens the row, and opening the row restores its charge, so the data that comes back is not needed.

A small table holds the weak rows. Each entry has a valid flag, a bank, a row, a two-bit interval class and a private countdown. Software or a boot sequence fills the table through a single write port. Every interval is counted in ticks of a millisecond timebase input. Refresh and read requests each go to a command arbiter over their own valid/ready pair. A mode input selects the uniform scheme instead. In that scheme every row is served by the baseline interval alone, and no weak-row reads are made.

Top module: `weak_row_refresh_sched`

## Requirements
- R1: Reset leaves every table entry invalid. It also holds `ref_valid`, `rd_valid` and `overdue` low, and sets the refresh countdown to the interval of the current mode.
- R2: With `uniform_mode` low, `ref_valid` rises after `GLOBAL_MS` ticks. It then stays high until a cycle with `ref_ready` high. The refresh countdown starts again when it expires, whether or not the earlier request has been taken.
- R3: With `uniform_mode` high, the refresh interval is `BASE_MS` ticks and `rd_valid` is never asserted. A change of `uniform_mode` restarts the refresh countdown with the interval of the new mode.
- R4: Class code 2'b00 gives an interval of `BASE_MS` ticks, and every other code gives `2*BASE_MS`. A valid entry becomes due on the interval-th tick after it was written or last served. `rd_bank` and `rd_row` show the stored address of the entry being offered. Invalid entries never request.
- R5: A due entry stays due until its read is accepted. A read is accepted when `rd_valid` and `rd_ready` are both high. Acceptance clears the due state and restarts that entry's countdown.
- R6: When several entries are due, `rd_idx` shows the lowest due index. One entry is served per accepted read.
- R7: While `ref_valid` is high, `rd_valid` is held low.
- R8: A write to an entry clears its due and overdue state and restarts its countdown from the new class. This holds even when the entry was due.
- R9: `overdue` goes high when a due entry's countdown expires again before the entry is served. It stays high until every such entry has been served or rewritten.
- R10: No countdown moves in a cycle without `tick_ms`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| uniform_mode | input | 1 | 1: uniform baseline refresh, no weak-row reads |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_valid | input | 1 | Valid flag to store |
| tbl_bank | input | BANK_W | Bank address to store |
| tbl_row | input | ROW_W | Row address to store |
| tbl_class | input | 2 | Interval class (2'b00 short, others long) |
| ref_valid | output | 1 | Chip-wide refresh request |
| ref_ready | input | 1 | Arbiter takes the refresh request |
| rd_valid | output | 1 | Weak-row read request |
| rd_ready | input | 1 | Arbiter takes the read request |
| rd_idx | output | IDX_W | Table index of the offered read |
| rd_bank | output | BANK_W | Bank of the offered read |
| rd_row | output | ROW_W | Row of the offered read |
| overdue | output | 1 | Some due entry missed a whole further interval |

## Verification
The bench builds the block with four entries, `BASE_MS` of 4 and `GLOBAL_MS` of 12. With these values a refresh expiry, both entry classes, several entries due at once, and an entry going overdue all happen within a few dozen ticks. The random phases vary how often the read port is ready, from never to usually. Periods with no ready let entries pile up and go overdue, and busier periods drain them in index order. Table writes and mode changes are mixed in. Directed steps at the start check the tick counts, a rewrite of a pending entry, and a mode switch.

// File: rtl/wrs_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the weak-row read-refresh scheduler.
// Assumes class codes are two bits wide; only 2'b00 selects the short interval.
package wrs_pkg;
    localparam logic [1:0] CLS_SHORT = 2'b00;

    // Interval multiple of the base period for a class code.
    function automatic int unsigned class_mult(input logic [1:0] cls);
        return (cls == CLS_SHORT) ? 1 : 2;
    endfunction
endpackage

// File: rtl/wrs_global_timer.sv
`timescale 1ns/1ps
// Chip-wide refresh timer.
// Counts ms ticks down from the mode's interval and raises a pending
// request on expiry. The request is held until it is accepted.
// Assumes tick is a single-cycle pulse. A mode change restarts the count.
module wrs_global_timer #(
    parameter int BASE_MS   = 64,
    parameter int GLOBAL_MS = 192,
    parameter int CNT_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic uniform,
    input  logic accept,
    output logic pend
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic             mode_q;
    logic             expire;

    // Interval chosen by the present mode.
    assign reload = uniform ? CNT_W'(BASE_MS) : CNT_W'(GLOBAL_MS);
    // Expiry only counts when the mode is steady.
    assign expire = tick && (uniform == mode_q) && (cnt <= CNT_W'(1));

    // Countdown with restart on expiry or mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= reload;
            mode_q <= uniform;
        end else begin
            mode_q <= uniform;
            if (uniform != mode_q)  cnt <= reload;
            else if (expire)        cnt <= reload;
            else if (tick)          cnt <= cnt - CNT_W'(1);
        end
    end

    // Pending request: set on expiry, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (expire) pend <= 1'b1;
        else if (accept) pend <= 1'b0;
    end

    // R2
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !accept |=> pend);
    // R10
    gcnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && (uniform == mode_q) |=> $stable(cnt));
endmodule

// File: rtl/wrs_entry.sv
`timescale 1ns/1ps
// One weak-row table entry: address, class, countdown, due and overdue flags.
// Assumes at most one of write/accept is meaningful per cycle; write wins.
// In uniform mode the entry is held idle with a fresh countdown.
module wrs_entry
    import wrs_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 16,
    parameter int BASE_MS = 64,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              uniform,
    input  logic              wr_en,
    input  logic              wr_valid,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [1:0]        wr_cls,
    input  logic              accept,
    output logic              valid,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic              pend,
    output logic              ovd
);
    logic [1:0]       cls;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload_cur;
    logic [CNT_W-1:0] reload_new;

    // Reload values for the stored class and the class being written.
    assign reload_cur = CNT_W'(class_mult(cls) * BASE_MS);
    assign reload_new = CNT_W'(class_mult(wr_cls) * BASE_MS);

    // Entry state update, priority: write, idle/serve, tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            bank  <= '0;
            row   <= '0;
            cls   <= '0;
            cnt   <= '0;
            pend  <= 1'b0;
            ovd   <= 1'b0;
        end else if (wr_en) begin
            valid <= wr_valid;
            bank  <= wr_bank;
            row   <= wr_row;
            cls   <= wr_cls;
            cnt   <= reload_new;
            pend  <= 1'b0;
            ovd   <= 1'b0;
        end else if (valid) begin
            if (uniform || accept) begin
                cnt  <= reload_cur;
                pend <= 1'b0;
                ovd  <= 1'b0;
            end else if (tick) begin
                if (cnt <= CNT_W'(1)) begin
                    cnt  <= reload_cur;
                    pend <= 1'b1;
                    if (pend) ovd <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !accept && !wr_en && !uniform |=> pend);
    // R9
    ovd_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovd |-> pend);
    // R10
    ecnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_en && !accept && !uniform |=> $stable(cnt));
endmodule

// File: rtl/wrs_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: lowest set request index wins.
// Purely combinational; assumes IW bits can hold N-1.
module wrs_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    // Scan upward and keep the first request found.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                any      = 1'b1;
                idx      = IW'(i);
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/weak_row_refresh_sched.sv
`timescale 1ns/1ps
// Weak-row read-refresh scheduler.
// Issues chip-wide refresh at a relaxed interval and keeps weak rows alive
// with ordinary reads on per-entry schedules. Refresh outranks reads.
// Assumes tick_ms is a one-cycle pulse and that NUM_ENTRIES >= 2.
module weak_row_refresh_sched
    import wrs_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int BANK_W      = 3,
    parameter int ROW_W       = 16,
    parameter int BASE_MS     = 64,
    parameter int GLOBAL_MS   = 192,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int MAX_IVL    = (GLOBAL_MS > 2 * BASE_MS) ? GLOBAL_MS : 2 * BASE_MS,
    localparam int CNT_W      = $clog2(MAX_IVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              uniform_mode,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [BANK_W-1:0] tbl_bank,
    input  logic [ROW_W-1:0]  tbl_row,
    input  logic [1:0]        tbl_class,
    output logic              ref_valid,
    input  logic              ref_ready,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_bank,
    output logic [ROW_W-1:0]  rd_row,
    output logic              overdue
);
    logic [NUM_ENTRIES-1:0] e_valid;
    logic [NUM_ENTRIES-1:0] e_pend;
    logic [NUM_ENTRIES-1:0] e_ovd;
    logic [NUM_ENTRIES-1:0] grant;
    logic [BANK_W-1:0]      e_bank [NUM_ENTRIES];
    logic [ROW_W-1:0]       e_row  [NUM_ENTRIES];
    logic                   any_pend;
    logic                   rd_fire;

    // Chip-wide refresh timer.
    wrs_global_timer #(
        .BASE_MS(BASE_MS), .GLOBAL_MS(GLOBAL_MS), .CNT_W(CNT_W)
    ) u_gtimer (
        .clk(clk), .rst_n(rst_n), .tick(tick_ms), .uniform(uniform_mode),
        .accept(ref_valid && ref_ready), .pend(ref_valid)
    );

    // One entry per table slot.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        wrs_entry #(
            .BANK_W(BANK_W), .ROW_W(ROW_W), .BASE_MS(BASE_MS), .CNT_W(CNT_W)
        ) u_entry (
            .clk(clk), .rst_n(rst_n), .tick(tick_ms), .uniform(uniform_mode),
            .wr_en(tbl_we && (tbl_idx == IDX_W'(g))),
            .wr_valid(tbl_valid), .wr_bank(tbl_bank), .wr_row(tbl_row),
            .wr_cls(tbl_class),
            .accept(rd_fire && grant[g]),
            .valid(e_valid[g]), .bank(e_bank[g]), .row(e_row[g]),
            .pend(e_pend[g]), .ovd(e_ovd[g])
        );
    end

    // Lowest due entry is offered first.
    wrs_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_pick (
        .req(e_pend), .any(any_pend), .idx(rd_idx), .grant(grant)
    );

    // Read offer: masked by uniform mode and by a pending refresh.
    assign rd_valid = !uniform_mode && !ref_valid && any_pend;
    assign rd_fire  = rd_valid && rd_ready;
    assign rd_bank  = e_bank[rd_idx];
    assign rd_row   = e_row[rd_idx];
    assign overdue  = |e_ovd;

    // R7
    ref_over_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> !rd_valid);
    // R3
    uniform_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uniform_mode |-> !rd_valid);
    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~e_pend) == '0));
    // R4
    invalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_pend & ~e_valid) == '0);
endmodule

// File: tb/sim_weak_row_refresh_sched.sv
`timescale 1ns/1ps
module sim_weak_row_refresh_sched;
    localparam int N   = 4;
    localparam int BMS = 4;
    localparam int GMS = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0, uniform_mode = 1'b0, tbl_we = 1'b0;
    logic [1:0] tbl_idx = '0;
    logic       tbl_valid = 1'b0;
    logic [2:0] tbl_bank = '0;
    logic [7:0] tbl_row = '0;
    logic [1:0] tbl_class = '0;
    logic       ref_ready = 1'b0, rd_ready = 1'b0;
    logic       ref_valid, rd_valid, overdue;
    logic [1:0] rd_idx;
    logic [2:0] rd_bank;
    logic [7:0] rd_row;

    int nchk = 0, nerr = 0;

    weak_row_refresh_sched #(
        .NUM_ENTRIES(N), .BANK_W(3), .ROW_W(8), .BASE_MS(BMS), .GLOBAL_MS(GMS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .uniform_mode(uniform_mode),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_bank(tbl_bank), .tbl_row(tbl_row), .tbl_class(tbl_class),
        .ref_valid(ref_valid), .ref_ready(ref_ready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx),
        .rd_bank(rd_bank), .rd_row(rd_row), .overdue(overdue)
    );

    always #2.5 clk = ~clk;

    // Requirement-level model state
    int gcnt; bit rpend, mq;
    bit ev[N], pend[N], ovd[N];
    int cnt[N], mb[N], mr[N], mc[N];

    function automatic int ivl(input int c);
        return (c == 0) ? BMS : 2 * BMS;
    endfunction
    function automatic int givl(input bit u);
        return u ? BMS : GMS;
    endfunction
    function automatic bit m_any();
        for (int i = 0; i < N; i++) if (pend[i]) return 1'b1;
        return 1'b0;
    endfunction
    function automatic int m_idx();
        for (int i = 0; i < N; i++) if (pend[i]) return i;
        return 0;
    endfunction
    function automatic bit m_rdv();
        return !uniform_mode && !rpend && m_any();
    endfunction
    function automatic bit m_ovd();
        for (int i = 0; i < N; i++) if (ovd[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        gcnt = givl(uniform_mode); mq = uniform_mode; rpend = 1'b0;
        for (int i = 0; i < N; i++) begin
            ev[i] = 0; pend[i] = 0; ovd[i] = 0; cnt[i] = 0; mb[i] = 0; mr[i] = 0; mc[i] = 0;
        end
    endtask

    // Advance the model by one cycle using the inputs now applied.
    task automatic m_step();
        bit racc, dacc, set;
        int gi;
        racc = rpend && ref_ready;
        dacc = m_rdv() && rd_ready;
        gi   = m_idx();
        set  = 1'b0;
        if (uniform_mode != mq) gcnt = givl(uniform_mode);
        else if (tick_ms) begin
            if (gcnt <= 1) begin gcnt = givl(uniform_mode); set = 1'b1; end
            else gcnt--;
        end
        rpend = set ? 1'b1 : (racc ? 1'b0 : rpend);
        mq = uniform_mode;
        for (int i = 0; i < N; i++) begin
            if (tbl_we && int'(tbl_idx) == i) begin
                ev[i] = tbl_valid; mb[i] = int'(tbl_bank); mr[i] = int'(tbl_row);
                mc[i] = int'(tbl_class); cnt[i] = ivl(mc[i]); pend[i] = 0; ovd[i] = 0;
            end else if (ev[i]) begin
                if (uniform_mode || (dacc && gi == i)) begin
                    cnt[i] = ivl(mc[i]); pend[i] = 0; ovd[i] = 0;
                end else if (tick_ms) begin
                    if (cnt[i] <= 1) begin
                        cnt[i] = ivl(mc[i]);
                        if (pend[i]) ovd[i] = 1;
                        pend[i] = 1;
                    end else cnt[i]--;
                end
            end
        end
    endtask

    task automatic compare();
        string t;
        chk(uniform_mode ? "R3" : "R2", "ref_valid", ref_valid, rpend);
        t = uniform_mode ? "R3" : ((rpend && m_any()) ? "R7" : "R5");
        chk(t, "rd_valid", rd_valid, m_rdv());
        if (m_rdv()) begin
            chk("R6", "rd_idx", rd_idx, m_idx());
            chk("R4", "rd_bank", rd_bank, mb[m_idx()]);
            chk("R4", "rd_row", rd_row, mr[m_idx()]);
        end
        chk("R9", "overdue", overdue, m_ovd());
    endtask

    task automatic step();
        m_step();
        @(negedge clk);
        compare();
    endtask

    task automatic tick_gap(input int k);
        for (int i = 0; i < k; i++) begin
            tick_ms = 1'b1; step(); tick_ms = 1'b0; step();
        end
    endtask

    initial begin
        #(200000 * 5);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        int rdp;
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        m_reset();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "ref_valid", ref_valid, 0);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "overdue", overdue, 0);

        // R4: short-class entry 2 becomes due on its 4th tick
        tbl_we = 1; tbl_idx = 2; tbl_valid = 1; tbl_bank = 3'd5; tbl_row = 8'h33; tbl_class = 2'b00;
        step();
        tbl_we = 0;
        tick_gap(3);
        chk("R4", "rd_valid after 3 ticks", rd_valid, 0);
        // R10: no tick, nothing moves
        repeat (10) step();
        chk("R10", "rd_valid without ticks", rd_valid, 0);
        tick_ms = 1; step(); tick_ms = 0;
        chk("R4", "rd_valid after 4 ticks", rd_valid, 1);
        chk("R4", "rd_idx", rd_idx, 2);
        chk("R4", "rd_bank", rd_bank, 5);

        // R8: rewrite a pending entry
        tbl_we = 1; tbl_class = 2'b01; step(); tbl_we = 0;
        chk("R8", "rd_valid after rewrite", rd_valid, 0);
        chk("R8", "overdue after rewrite", overdue, 0);

        // R3: uniform mode, refresh after BASE ticks, no reads
        uniform_mode = 1; step();
        chk("R3", "rd_valid in uniform", rd_valid, 0);
        tick_gap(3);
        chk("R3", "ref_valid after 3 ticks", ref_valid, 0);
        tick_ms = 1; step(); tick_ms = 0;
        chk("R3", "ref_valid after 4 ticks", ref_valid, 1);
        ref_ready = 1; step(); ref_ready = 0;
        chk("R2", "ref_valid after accept", ref_valid, 0);
        uniform_mode = 0; step();

        // Random phase with lockstep model
        rdp = 0;
        for (int n = 0; n < 30000; n++) begin
            if (n % 2000 == 0) begin
                case ($urandom % 3)
                    0: rdp = 0;
                    1: rdp = 20;
                    default: rdp = 80;
                endcase
            end
            tick_ms   = ($urandom % 3) == 0;
            ref_ready = ($urandom % 2) == 0;
            rd_ready  = ($urandom % 100) < rdp;
            tbl_we    = ($urandom % 40) == 0;
            tbl_idx   = 2'($urandom % 4);
            tbl_valid = ($urandom % 8) != 0;
            tbl_bank  = 3'($urandom);
            tbl_row   = 8'($urandom);
            tbl_class = 2'($urandom);
            if (($urandom % 3000) == 0) uniform_mode = !uniform_mode;
            step();
        end
        tick_ms = 0; tbl_we = 0;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule